// File: doc/BRIEF.md
# Card Reader Readiness Controller

This block models the hopper of a punched-card reader that sits behind a channel-style adapter. It keeps a count of buffered card images and decides when the reader is Ready. It also produces the device status word that the host reads after each read command.

Decks are loaded by an append pulse that carries the number of new images. A Start pulse brings a halted reader back on line. A last-card switch tells the block that the deck is complete. A read-complete pulse marks the end of each read command. When one image remains, it stands for the card held in the pre-read station, so the reader drops out of Ready unless the last-card switch allows that final card to be read. When the final card is taken, the status word flags it.

Storing and moving the card data, decoding host commands and raising interrupts are handled by other blocks.

Top module: `hopper_ready_ctrl`

## Requirements
- R1: After reset, card_cnt is 0, ready is 0, status is 0x0000 and ovf_err is 0.
- R2: An append pulse with a non-zero append_cnt adds that value to card_cnt. If the new count is at least 2, ready becomes 1 and status bit 15 (not-ready) clears. An append of 0 images has no effect.
- R3: Appends saturate card_cnt at 65535. An append whose sum would exceed 65535 raises ovf_err for exactly the one cycle after that append is taken.
- R4: A read-complete pulse is accepted only when ready is 1 and card_cnt is non-zero. An accepted read lowers card_cnt by one. If the result is 2 or more, ready stays 1.
- R5: If an accepted read leaves card_cnt at 1 while lastcard_en is 0, ready becomes 0 and status bit 15 is set.
- R6: If an accepted read leaves card_cnt at 1 while lastcard_en is 1, ready stays 1 and status is unchanged.
- R7: If an accepted read leaves card_cnt at 0, status bit 14 (last-card) and bit 15 are both set, and ready becomes 0.
- R8: A Start pulse while ready is 0, card_cnt is 1 and lastcard_en is 1 sets ready and clears status bit 15. A Start pulse under any other condition is ignored.
- R9: A read-complete pulse while ready is 0 or card_cnt is 0 leaves card_cnt, ready and status unchanged.
- R10: Status bit 14 is cleared by a stat_clr pulse or by an accepted append. If a read sets bit 14 in the same cycle as stat_clr, the set wins.
- R11: When several event pulses arrive in the same cycle, only one is taken. An append is taken first, then a read, then a Start. The pulses not taken are dropped.
- R12: Status bits 13 down to 0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| append_pulse | input | 1 | One-cycle request to add a deck |
| append_cnt | input | 16 | Number of card images in the deck being added |
| start_pulse | input | 1 | One-cycle Start button press |
| lastcard_en | input | 1 | Last-card switch: the deck is complete |
| read_done | input | 1 | One-cycle pulse at the end of a read command |
| stat_clr | input | 1 | One-cycle pulse that clears the last-card status bit |
| ready | output | 1 | Reader Ready flag |
| status | output | 16 | Status word: bit 15 not-ready, bit 14 last-card, all other bits zero |
| card_cnt | output | 16 | Number of buffered card images |
| ovf_err | output | 1 | One-cycle flag for an append that saturated the count |

## Verification
The embedded properties check several rules on every cycle:
- Ready is never held with an empty hopper.
- A set last-card bit implies an empty, halted reader.
- The reserved status bits stay zero.
- The count moves only on a taken append or read.
- A read down to one card with the switch off always halts the reader.

The directed scenarios are needed for the rest. They show the full sequences:
- the halt at the pre-read card followed by a restart by append;
- the Start-driven last-card restart and the flagged final read;
- the priority between pulses in the same cycle;
- the contest between a last-card set and stat_clr in one cycle;
- saturation with its single-cycle error pulse.

// File: rtl/hopper_pkg.sv
package hopper_pkg;

    localparam int CNT_W   = 16;
    localparam int STAT_W  = 16;
    localparam int NR_BIT  = 15;
    localparam int LC_BIT  = 14;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_APPEND = 2'd1,
        EV_READ   = 2'd2,
        EV_START  = 2'd3
    } hop_ev_e;

    typedef struct packed {
        hop_ev_e kind;
        cnt_t    add;
    } hop_evt_t;

    typedef struct packed {
        cnt_t value;
        logic ovf;
    } sat_sum_t;

    typedef struct packed {
        logic not_ready;
        logic last_card;
    } hop_stat_t;

    function automatic sat_sum_t sat_add(input cnt_t a, input cnt_t b);
        logic [CNT_W:0] wide;
        sat_sum_t r;
        wide = {1'b0, a} + {1'b0, b};
        r.ovf = wide[CNT_W];
        r.value = wide[CNT_W] ? {CNT_W{1'b1}} : wide[CNT_W-1:0];
        return r;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input hop_stat_t s);
        logic [STAT_W-1:0] w;
        w = '0;
        w[NR_BIT] = s.not_ready;
        w[LC_BIT] = s.last_card;
        return w;
    endfunction

endpackage

// File: rtl/hopper_event_arb.sv
module hopper_event_arb
    import hopper_pkg::*;
(
    input  logic     append_pulse,
    input  cnt_t     append_cnt,
    input  logic     read_done,
    input  logic     start_pulse,
    input  logic     lastcard_en,
    input  logic     ready,
    input  cnt_t     count,
    output hop_evt_t evt
);
    logic append_ok, read_ok, start_ok;

    assign append_ok = append_pulse && (append_cnt != '0);
    assign read_ok   = read_done && ready && (count != '0);
    assign start_ok  = start_pulse && !ready && (count == cnt_t'(1)) && lastcard_en;

    always_comb begin
        evt.add = append_cnt;
        if (append_ok)     evt.kind = EV_APPEND;
        else if (read_ok)  evt.kind = EV_READ;
        else if (start_ok) evt.kind = EV_START;
        else               evt.kind = EV_NONE;
    end

endmodule

// File: rtl/hopper_counter.sv
module hopper_counter
    import hopper_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hop_evt_t evt,
    output cnt_t     count,
    output cnt_t     count_nxt,
    output logic     ovf_err
);
    sat_sum_t sum;

    always_comb begin
        sum = sat_add(count, evt.add);
        unique case (evt.kind)
            EV_APPEND: count_nxt = sum.value;
            EV_READ:   count_nxt = count - cnt_t'(1);
            default:   count_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            ovf_err <= 1'b0;
        end else begin
            count   <= count_nxt;
            ovf_err <= (evt.kind == EV_APPEND) && sum.ovf;
        end
    end

    // R9: count moves only on a taken append or read
    p_hold_count_r9: assert property (@(posedge clk) disable iff (rst)
        (evt.kind != EV_APPEND && evt.kind != EV_READ) |=> $stable(count));

    // R3: a saturating append leaves the count at its maximum
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_err |-> (count == {CNT_W{1'b1}}));

    // R4: a taken read lowers the count by one
    p_read_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.kind == EV_READ) |=> (count == $past(count) - cnt_t'(1)));

endmodule

// File: rtl/hopper_ready_fsm.sv
module hopper_ready_fsm
    import hopper_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hop_ev_e kind,
    input  cnt_t    count_nxt,
    input  logic    lastcard_en,
    output logic    ready,
    output logic    ready_nxt
);
    always_comb begin
        ready_nxt = ready;
        unique case (kind)
            EV_APPEND: ready_nxt = ready || (count_nxt >= cnt_t'(2));
            EV_READ: begin
                if (count_nxt == '0)
                    ready_nxt = 1'b0;
                else if (count_nxt == cnt_t'(1) && !lastcard_en)
                    ready_nxt = 1'b0;
            end
            EV_START:  ready_nxt = 1'b1;
            default:   ready_nxt = ready;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ready <= 1'b0;
        else     ready <= ready_nxt;
    end

    // R5: a read down to the pre-read card with the switch off halts the reader
    p_halt_preread_r5: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_READ && count_nxt == cnt_t'(1) && !lastcard_en) |=> !ready);

    // R8: Start always brings the reader on line
    p_start_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_START) |=> ready);

endmodule

// File: rtl/hopper_status_reg.sv
module hopper_status_reg
    import hopper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hop_ev_e           kind,
    input  cnt_t              count_nxt,
    input  logic              ready_nxt,
    input  logic              stat_clr,
    output logic [STAT_W-1:0] status
);
    hop_stat_t st, st_nxt;

    always_comb begin
        st_nxt = st;
        if (ready_nxt)
            st_nxt.not_ready = 1'b0;
        else if (kind == EV_READ)
            st_nxt.not_ready = 1'b1;

        if (kind == EV_READ && count_nxt == '0)
            st_nxt.last_card = 1'b1;
        else if (stat_clr || kind == EV_APPEND)
            st_nxt.last_card = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nxt;
    end

    assign status = pack_status(st);

    // R12: reserved bits stay zero
    p_reserved_zero_r12: assert property (@(posedge clk) disable iff (rst)
        status[LC_BIT-1:0] == '0);

    // R10: a pulse of stat_clr with no competing set clears the last-card bit
    p_clear_lc_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !(kind == EV_READ && count_nxt == '0)) |=> !status[LC_BIT]);

endmodule

// File: rtl/hopper_ready_ctrl.sv
module hopper_ready_ctrl
    import hopper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              append_pulse,
    input  logic [CNT_W-1:0]  append_cnt,
    input  logic              start_pulse,
    input  logic              lastcard_en,
    input  logic              read_done,
    input  logic              stat_clr,
    output logic              ready,
    output logic [STAT_W-1:0] status,
    output logic [CNT_W-1:0]  card_cnt,
    output logic              ovf_err
);
    hop_evt_t evt;
    cnt_t     count_nxt;
    logic     ready_nxt;

    hopper_event_arb u_arb (
        .append_pulse (append_pulse),
        .append_cnt   (append_cnt),
        .read_done    (read_done),
        .start_pulse  (start_pulse),
        .lastcard_en  (lastcard_en),
        .ready        (ready),
        .count        (card_cnt),
        .evt          (evt)
    );

    hopper_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .count     (card_cnt),
        .count_nxt (count_nxt),
        .ovf_err   (ovf_err)
    );

    hopper_ready_fsm u_rdy (
        .clk         (clk),
        .rst         (rst),
        .kind        (evt.kind),
        .count_nxt   (count_nxt),
        .lastcard_en (lastcard_en),
        .ready       (ready),
        .ready_nxt   (ready_nxt)
    );

    hopper_status_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .kind      (evt.kind),
        .count_nxt (count_nxt),
        .ready_nxt (ready_nxt),
        .stat_clr  (stat_clr),
        .status    (status)
    );

    // R4: Ready is never held with an empty hopper
    p_ready_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        ready |-> (card_cnt != '0));

    // R7: a set last-card bit means an empty, halted reader
    p_lastcard_empty_r7: assert property (@(posedge clk) disable iff (rst)
        status[LC_BIT] |-> (!ready && card_cnt == '0 && status[NR_BIT]));

    // R9: a read pulse while halted changes nothing
    p_read_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (read_done && !ready && !append_pulse && !start_pulse && !stat_clr)
        |=> ($stable(card_cnt) && $stable(status) && !ready));

endmodule

// File: tb/hopper_ready_ctrl_bench.sv
module hopper_ready_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        append_pulse, start_pulse, lastcard_en, read_done, stat_clr;
    logic [15:0] append_cnt;
    logic        ready, ovf_err;
    logic [15:0] status, card_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    hopper_ready_ctrl u_hopper_ready_ctrl (
        .clk(clk), .rst(rst),
        .append_pulse(append_pulse), .append_cnt(append_cnt),
        .start_pulse(start_pulse), .lastcard_en(lastcard_en),
        .read_done(read_done), .stat_clr(stat_clr),
        .ready(ready), .status(status), .card_cnt(card_cnt), .ovf_err(ovf_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Sample all outputs; status reserved bits checked every time (R12)
    task automatic expect_state(input string req, input logic [15:0] cnt,
                                input logic rdy, input logic [15:0] st);
        chk(req, "card_cnt", 32'(card_cnt), 32'(cnt));
        chk(req, "ready", 32'(ready), 32'(rdy));
        chk(req, "status", 32'(status), 32'(st));
        chk("R12", "reserved status bits", 32'(status & 16'h3FFF), 32'h0);
    endtask

    // Drive one cycle of pulses at a falling edge, release at the next;
    // the registered result is then visible.
    task automatic pulse(input logic ap, input logic [15:0] n, input logic rd,
                         input logic st, input logic clr);
        @(negedge clk);
        append_pulse = ap; append_cnt = n; read_done = rd;
        start_pulse = st;  stat_clr = clr;
        @(negedge clk);
        append_pulse = 1'b0; append_cnt = '0; read_done = 1'b0;
        start_pulse = 1'b0;  stat_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        append_pulse = 1'b0; append_cnt = '0; read_done = 1'b0;
        start_pulse = 1'b0; stat_clr = 1'b0; lastcard_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_r1();
        do_reset();
        expect_state("R1", 16'd0, 1'b0, 16'h0000);
        chk("R1", "ovf_err", 32'(ovf_err), 32'h0);
    endtask

    task automatic t_empty_ignores();
        pulse(0, 0, 1, 0, 0);
        expect_state("R9", 16'd0, 1'b0, 16'h0000);
        lastcard_en = 1'b1;
        pulse(0, 0, 0, 1, 0);
        expect_state("R8", 16'd0, 1'b0, 16'h0000);
        lastcard_en = 1'b0;
        pulse(1, 16'd0, 0, 0, 0);
        expect_state("R2", 16'd0, 1'b0, 16'h0000);
    endtask

    task automatic t_preread_halt();
        pulse(1, 16'd3, 0, 0, 0);
        expect_state("R2", 16'd3, 1'b1, 16'h0000);
        pulse(0, 0, 1, 0, 0);
        expect_state("R4", 16'd2, 1'b1, 16'h0000);
        pulse(0, 0, 1, 0, 0);
        expect_state("R5", 16'd1, 1'b0, 16'h8000);
        pulse(0, 0, 1, 0, 0);
        expect_state("R9", 16'd1, 1'b0, 16'h8000);
        pulse(0, 0, 0, 1, 0);
        expect_state("R8", 16'd1, 1'b0, 16'h8000);
        pulse(1, 16'd2, 0, 0, 0);
        expect_state("R2", 16'd3, 1'b1, 16'h0000);
    endtask

    task automatic t_lastcard_start();
        pulse(0, 0, 1, 0, 0);
        pulse(0, 0, 1, 0, 0);
        expect_state("R5", 16'd1, 1'b0, 16'h8000);
        lastcard_en = 1'b1;
        pulse(0, 0, 0, 1, 0);
        expect_state("R8", 16'd1, 1'b1, 16'h0000);
        pulse(0, 0, 1, 0, 0);
        expect_state("R7", 16'd0, 1'b0, 16'hC000);
        pulse(0, 0, 0, 0, 1);
        expect_state("R10", 16'd0, 1'b0, 16'h8000);
    endtask

    task automatic t_lastcard_switch();
        pulse(1, 16'd2, 0, 0, 0);
        expect_state("R2", 16'd2, 1'b1, 16'h0000);
        pulse(0, 0, 1, 0, 0);
        expect_state("R6", 16'd1, 1'b1, 16'h0000);
        pulse(0, 0, 1, 0, 0);
        expect_state("R7", 16'd0, 1'b0, 16'hC000);
        pulse(1, 16'd5, 0, 0, 0);
        expect_state("R10", 16'd5, 1'b1, 16'h0000);
    endtask

    task automatic t_priority_r11();
        pulse(1, 16'd1, 1, 0, 0);
        expect_state("R11", 16'd6, 1'b1, 16'h0000);
        pulse(0, 0, 1, 1, 0);
        expect_state("R11", 16'd5, 1'b1, 16'h0000);
    endtask

    task automatic t_set_beats_clear();
        for (int i = 0; i < 4; i++) pulse(0, 0, 1, 0, 0);
        expect_state("R6", 16'd1, 1'b1, 16'h0000);
        pulse(0, 0, 1, 0, 1);
        expect_state("R10", 16'd0, 1'b0, 16'hC000);
        lastcard_en = 1'b0;
    endtask

    task automatic t_saturate_r3();
        do_reset();
        pulse(1, 16'hFFFF, 0, 0, 0);
        chk("R3", "card_cnt full", 32'(card_cnt), 32'hFFFF);
        chk("R3", "ovf_err exact fit", 32'(ovf_err), 32'h0);
        pulse(1, 16'd1, 0, 0, 0);
        chk("R3", "card_cnt saturated", 32'(card_cnt), 32'hFFFF);
        chk("R3", "ovf_err raised", 32'(ovf_err), 32'h1);
        @(negedge clk);
        chk("R3", "ovf_err one cycle", 32'(ovf_err), 32'h0);
        chk("R3", "ready", 32'(ready), 32'h1);
    endtask

    initial begin
        t_reset_r1();
        t_empty_ignores();
        t_preread_halt();
        t_lastcard_start();
        t_lastcard_switch();
        t_priority_r11();
        t_set_beats_clear();
        t_saturate_r3();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule